// File: doc/BRIEF.md
# Host-to-Card Memory Window Translator

This block turns host memory accesses into accesses to a removable card's memory. It holds a small bank of programmable windows. Each window has an enable, a host base address, a card base address, a size, and a flag that selects the card's attribute space or its common space. When the host presents an address, every enabled window compares it in parallel. On a hit, one cycle later the block raises a strobe. Alongside the strobe it gives the relocated card address, the selected space and the number of the winning window.

Windows are loaded through a single-cycle write port that replaces one window's settings in full. The port enforces the placement rules for windows. A size must be a power of two, at least 4 KB and at most 16 MB. The host base and the card base must both be multiples of the size. A write that breaks a rule is dropped, and a one-cycle error pulse reports it. Bus timing toward the card, wait states and data steering are handled elsewhere.

Top module: `mwin_xlate`

## Requirements
- R1: After reset every window is disabled, `xl_strobe` is low and `cfg_err` is low, so no access can hit.
- R2: An access with `acc_valid` high that falls in an enabled window raises `xl_strobe` on the following cycle. At that point `xl_addr` equals the window's card base plus (access address minus host base), truncated to 24 bits.
- R3: On a hit, `xl_attr` reports the window's space flag (1 = attribute memory, 0 = common memory), and `xl_win` gives the window number.
- R4: An address outside every enabled window, or a cycle with `acc_valid` low, leaves `xl_strobe` low on the following cycle.
- R5: When several enabled windows contain the address, the lowest-numbered window supplies `xl_addr`, `xl_attr` and `xl_win`.
- R6: An enabling write whose size is not a power of two is rejected. The window keeps its previous settings, and `cfg_err` is high for exactly the cycle after the write.
- R7: An enabling write whose size is below 4096 bytes is rejected in the same way. A size of exactly 2^24 bytes is accepted, and it covers the card's whole 24-bit space.
- R8: An enabling write whose host base or card base is not a multiple of the size is rejected in the same way.
- R9: A write that passes the rules drives `cfg_err` low on the next cycle. An access presented in the same cycle as that write is still translated with the window's old settings. The new settings apply from the next cycle on.
- R10: A write with `cfg_en` low is always accepted and disables the window, so it no longer hits.
- R11: A window of size S and host base B hits for B+S-1 and misses for B+S.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write strobe for one window's settings |
| cfg_sel | input | 2 | Window number being written |
| cfg_en | input | 1 | Window enable to be written |
| cfg_attr | input | 1 | Space flag: 1 attribute, 0 common |
| cfg_host_base | input | 32 | Host base address |
| cfg_card_base | input | 24 | Card base address |
| cfg_size | input | 25 | Window size in bytes |
| cfg_err | output | 1 | One-cycle pulse for a rejected write |
| acc_valid | input | 1 | Host access present |
| acc_addr | input | 32 | Host access address |
| xl_strobe | output | 1 | Registered hit strobe toward the card |
| xl_addr | output | 24 | Translated card address |
| xl_attr | output | 1 | Selected card space |
| xl_win | output | 2 | Number of the winning window |

## Verification
A window rewrite and a lookup through that same window can land on the same clock edge. The bench provokes this by moving window 3 to a new host region. In the write's cycle it presents an address that only the new placement covers. A miss is expected in that cycle, then a hit at the new card address on the next access, while the old region now misses. Overlapping windows and rejected writes are judged the same way. After each one, an access goes through the affected window, so the settings are observed at the outputs.

// File: rtl/mwin_pkg.sv
package mwin_pkg;
   // space selected by a window
   typedef enum logic {
      SPACE_COMMON = 1'b0,
      SPACE_ATTR   = 1'b1
   } space_e;
endpackage

// File: rtl/mwin_rule_check.sv
// Validates one window write against the placement rules.
module mwin_rule_check #(
   parameter int CARD_AW  = 24,
   parameter int MIN_LOG2 = 12,
   localparam int SZW     = CARD_AW + 1
) (
   input  logic               en,
   input  logic [SZW-1:0]     size,
   input  logic [CARD_AW-1:0] host_low,
   input  logic [CARD_AW-1:0] card_base,
   output logic [CARD_AW-1:0] mask,
   output logic               ok
);
   logic [SZW-1:0] size_m1;
   logic           is_pow2, big_enough, aligned;

   always_comb begin
      size_m1    = size - 1'b1;
      mask       = size_m1[CARD_AW-1:0];
      is_pow2    = (size != '0) && ((size & size_m1) == '0);
      big_enough = size >= (SZW'(1) << MIN_LOG2);
      aligned    = ((host_low | card_base) & mask) == '0;
      ok         = !en || (is_pow2 && big_enough && aligned);
   end
endmodule

// File: rtl/mwin_slot.sv
// One window: settings register plus its address comparator.
module mwin_slot #(
   parameter int HOST_AW  = 32,
   parameter int CARD_AW  = 24,
   parameter int MIN_LOG2 = 12
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic               new_en,
   input  logic               new_attr,
   input  logic [HOST_AW-1:0] new_host,
   input  logic [CARD_AW-1:0] new_card,
   input  logic [CARD_AW-1:0] new_mask,
   input  logic [HOST_AW-1:0] acc_addr,
   output logic               hit,
   output logic [CARD_AW-1:0] card_addr,
   output logic               attr
);
   import mwin_pkg::*;

   logic               en_q;
   space_e             space_q;
   logic [HOST_AW-1:0] host_q;
   logic [CARD_AW-1:0] card_q;
   logic [CARD_AW-1:0] mask_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q    <= 1'b0;
         space_q <= SPACE_COMMON;
         host_q  <= '0;
         card_q  <= '0;
         mask_q  <= '0;
      end else if (load) begin
         en_q    <= new_en;
         space_q <= space_e'(new_attr);
         host_q  <= new_host;
         card_q  <= new_card;
         mask_q  <= new_mask;
      end
   end

   logic upper_eq, lower_eq;
   always_comb begin
      upper_eq  = acc_addr[HOST_AW-1:CARD_AW] == host_q[HOST_AW-1:CARD_AW];
      lower_eq  = (acc_addr[CARD_AW-1:0] & ~mask_q) == host_q[CARD_AW-1:0];
      hit       = en_q && upper_eq && lower_eq;
      card_addr = card_q | (acc_addr[CARD_AW-1:0] & mask_q);
      attr      = (space_q == SPACE_ATTR);
   end

   // R8: an enabled window holds bases aligned to its size
   a_r8_bases_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      en_q |-> (((host_q[CARD_AW-1:0] | card_q) & mask_q) == '0));
   // R6/R7: an enabled window's mask is a run of low ones of at least MIN_LOG2 bits
   a_r6_mask_shape: assert property (@(posedge clk) disable iff (!rst_n)
      en_q |-> ((CARD_AW'(mask_q + 1'b1) & mask_q) == '0
                && mask_q[MIN_LOG2-1:0] == '1));
endmodule

// File: rtl/mwin_prio.sv
// Fixed-priority pick: lowest index wins.
module mwin_prio #(
   parameter int N    = 4,
   localparam int IW  = $clog2(N)
) (
   input  logic [N-1:0]  req,
   output logic [N-1:0]  grant,
   output logic [IW-1:0] idx,
   output logic          any
);
   always_comb begin
      grant = '0;
      idx   = '0;
      any   = |req;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) begin
            grant = '0;
            grant[i] = 1'b1;
            idx   = IW'(i);
         end
      end
   end

   // R5: at most one window is granted, and only a requesting one
   always_comb begin
      a_r5_grant_onehot: assert ($onehot0(grant) && ((grant & ~req) == '0));
   end
endmodule

// File: rtl/mwin_xlate.sv
// Host-to-card memory window translator, top level.
module mwin_xlate #(
   parameter int NUM_WIN  = 4,
   parameter int HOST_AW  = 32,
   parameter int CARD_AW  = 24,
   parameter int MIN_LOG2 = 12,
   localparam int IW      = $clog2(NUM_WIN),
   localparam int SZW     = CARD_AW + 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_we,
   input  logic [IW-1:0]      cfg_sel,
   input  logic               cfg_en,
   input  logic               cfg_attr,
   input  logic [HOST_AW-1:0] cfg_host_base,
   input  logic [CARD_AW-1:0] cfg_card_base,
   input  logic [SZW-1:0]     cfg_size,
   output logic               cfg_err,
   input  logic               acc_valid,
   input  logic [HOST_AW-1:0] acc_addr,
   output logic               xl_strobe,
   output logic [CARD_AW-1:0] xl_addr,
   output logic               xl_attr,
   output logic [IW-1:0]      xl_win
);
   // elaboration-time parameter checks
   if (NUM_WIN < 4)             $error("NUM_WIN must be at least 4");
   if (HOST_AW <= CARD_AW)      $error("HOST_AW must exceed CARD_AW");
   if (MIN_LOG2 >= CARD_AW)     $error("MIN_LOG2 must be below CARD_AW");

   logic [CARD_AW-1:0] new_mask;
   logic               rule_ok, sel_ok;

   mwin_rule_check #(.CARD_AW(CARD_AW), .MIN_LOG2(MIN_LOG2)) u_check (
      .en        (cfg_en),
      .size      (cfg_size),
      .host_low  (cfg_host_base[CARD_AW-1:0]),
      .card_base (cfg_card_base),
      .mask      (new_mask),
      .ok        (rule_ok)
   );

   assign sel_ok = 32'(cfg_sel) < NUM_WIN;

   logic [NUM_WIN-1:0] slot_hit;
   logic [CARD_AW-1:0] slot_addr [NUM_WIN];
   logic [NUM_WIN-1:0] slot_attr;

   for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
      mwin_slot #(.HOST_AW(HOST_AW), .CARD_AW(CARD_AW), .MIN_LOG2(MIN_LOG2)) u_slot (
         .clk       (clk),
         .rst_n     (rst_n),
         .load      (cfg_we && rule_ok && sel_ok && (cfg_sel == IW'(g))),
         .new_en    (cfg_en),
         .new_attr  (cfg_attr),
         .new_host  (cfg_host_base),
         .new_card  (cfg_card_base),
         .new_mask  (new_mask),
         .acc_addr  (acc_addr),
         .hit       (slot_hit[g]),
         .card_addr (slot_addr[g]),
         .attr      (slot_attr[g])
      );
   end

   logic [NUM_WIN-1:0] grant;
   logic [IW-1:0]      win_idx;
   logic               any_hit;

   mwin_prio #(.N(NUM_WIN)) u_prio (
      .req   (slot_hit),
      .grant (grant),
      .idx   (win_idx),
      .any   (any_hit)
   );

   logic [CARD_AW-1:0] pick_addr;
   logic               pick_attr;
   always_comb begin
      pick_addr = '0;
      pick_attr = 1'b0;
      for (int i = 0; i < NUM_WIN; i++) begin
         if (grant[i]) begin
            pick_addr = pick_addr | slot_addr[i];
            pick_attr = pick_attr | slot_attr[i];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         xl_strobe <= 1'b0;
         xl_addr   <= '0;
         xl_attr   <= 1'b0;
         xl_win    <= '0;
         cfg_err   <= 1'b0;
      end else begin
         xl_strobe <= acc_valid && any_hit;
         xl_addr   <= pick_addr;
         xl_attr   <= pick_attr;
         xl_win    <= win_idx;
         cfg_err   <= cfg_we && !(rule_ok && sel_ok);
      end
   end

   // R4: a strobe needs an access in the previous cycle
   a_r4_strobe_needs_access: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_valid |=> !xl_strobe);
   // R6: an error pulse only follows a write
   a_r6_err_after_write: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_we |=> !cfg_err);
   // R10: a disabling write is never flagged
   a_r10_disable_accepted: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && !cfg_en && sel_ok) |=> !cfg_err);
endmodule

// File: tb/tb_mwin_xlate.sv
module tb_mwin_xlate;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_sel = '0;
   logic        cfg_en = 1'b0;
   logic        cfg_attr = 1'b0;
   logic [31:0] cfg_host_base = '0;
   logic [23:0] cfg_card_base = '0;
   logic [24:0] cfg_size = '0;
   logic        cfg_err;
   logic        acc_valid = 1'b0;
   logic [31:0] acc_addr = '0;
   logic        xl_strobe;
   logic [23:0] xl_addr;
   logic        xl_attr;
   logic [1:0]  xl_win;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   mwin_xlate dut (.*);

   task automatic chk(input bit ok, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", what, act, exp);
      end
   endtask

   // one write; returns cfg_err observed after the edge
   task automatic wr(input int w, input bit en, input bit at, input logic [31:0] hb,
                     input logic [23:0] cb, input logic [24:0] sz, output bit err);
      cfg_sel = 2'(w); cfg_en = en; cfg_attr = at;
      cfg_host_base = hb; cfg_card_base = cb; cfg_size = sz; cfg_we = 1'b1;
      @(posedge clk); #1;
      cfg_we = 1'b0;
      err = cfg_err;
   endtask

   task automatic acc(input logic [31:0] a);
      acc_valid = 1'b1; acc_addr = a;
      @(posedge clk); #1;
      acc_valid = 1'b0;
   endtask

   task automatic expect_hit(input string tag, input logic [23:0] ea, input bit eat, input int ew);
      chk(xl_strobe, {tag, " strobe"}, int'(xl_strobe), 1);
      chk(xl_addr == ea, {tag, " addr"}, int'(xl_addr), int'(ea));
      chk(xl_attr == eat, {tag, " attr"}, int'(xl_attr), int'(eat));
      chk(xl_win == 2'(ew), {tag, " win"}, int'(xl_win), ew);
   endtask

   task automatic expect_miss(input string tag);
      chk(!xl_strobe, {tag, " strobe"}, int'(xl_strobe), 0);
   endtask

   task automatic t_reset();
      chk(!xl_strobe, "R1 strobe after reset", int'(xl_strobe), 0);
      chk(!cfg_err, "R1 err after reset", int'(cfg_err), 0);
      acc(32'h0010_0123);
      expect_miss("R1 all windows off");
   endtask

   task automatic t_basic();
      bit e;
      wr(0, 1, 0, 32'h0010_0000, 24'h00_2000, 25'h1000, e);
      chk(!e, "R9 good write no err", int'(e), 0);
      acc(32'h0010_0123);
      expect_hit("R2 basic", 24'h00_2123, 0, 0);
      @(posedge clk); #1;
      expect_miss("R4 idle cycle");
      acc(32'h1234_5678);
      expect_miss("R4 no window");
   endtask

   task automatic t_attr_bound();
      bit e;
      wr(1, 1, 1, 32'h8000_0000, 24'h03_0000, 25'h1_0000, e);
      acc(32'h8000_ABCD);
      expect_hit("R3 attr space", 24'h03_ABCD, 1, 1);
      acc(32'h8000_FFFF);
      expect_hit("R11 last byte", 24'h03_FFFF, 1, 1);
      acc(32'h8001_0000);
      expect_miss("R11 one past end");
   endtask

   task automatic t_prio();
      bit e;
      wr(2, 1, 0, 32'h8000_0000, 24'h10_0000, 25'h10_0000, e);
      acc(32'h8000_0010);
      expect_hit("R5 overlap low wins", 24'h03_0010, 1, 1);
      acc(32'h8008_0000);
      expect_hit("R5 only win2", 24'h18_0000, 0, 2);
   endtask

   task automatic t_disable();
      bit e;
      wr(2, 0, 0, 32'h0000_0123, 24'h00_0001, 25'h3, e);
      chk(!e, "R10 disable write accepted", int'(e), 0);
      acc(32'h8008_0000);
      expect_miss("R10 disabled window");
   endtask

   task automatic t_rejects();
      bit e;
      wr(0, 1, 1, 32'h0010_0000, 24'h00_0000, 25'h3000, e);
      chk(e, "R6 non pow2 err", int'(e), 1);
      @(posedge clk); #1;
      chk(!cfg_err, "R6 err lasts one cycle", int'(cfg_err), 0);
      acc(32'h0010_0123);
      expect_hit("R6 old kept", 24'h00_2123, 0, 0);
      wr(0, 1, 0, 32'h0020_0000, 24'h00_0000, 25'h800, e);
      chk(e, "R7 below 4K err", int'(e), 1);
      acc(32'h0010_0123);
      expect_hit("R7 old kept", 24'h00_2123, 0, 0);
      wr(0, 1, 0, 32'h0010_0800, 24'h00_2000, 25'h1000, e);
      chk(e, "R8 host misaligned err", int'(e), 1);
      wr(0, 1, 0, 32'h0030_0000, 24'h00_2400, 25'h1000, e);
      chk(e, "R8 card misaligned err", int'(e), 1);
      acc(32'h0010_0123);
      expect_hit("R8 old kept", 24'h00_2123, 0, 0);
   endtask

   task automatic t_full_size();
      bit e;
      wr(3, 1, 0, 32'h4000_0000, 24'h00_0000, 25'h100_0000, e);
      chk(!e, "R7 16MB accepted", int'(e), 0);
      acc(32'h40AB_CDEF);
      expect_hit("R7 16MB window", 24'hAB_CDEF, 0, 3);
   endtask

   task automatic t_same_cycle();
      // rewrite window 3 while accessing its new region
      cfg_sel = 2'd3; cfg_en = 1'b1; cfg_attr = 1'b1;
      cfg_host_base = 32'h6000_0000; cfg_card_base = 24'h00_5000; cfg_size = 25'h1000;
      cfg_we = 1'b1; acc_valid = 1'b1; acc_addr = 32'h6000_0004;
      @(posedge clk); #1;
      cfg_we = 1'b0; acc_valid = 1'b0;
      expect_miss("R9 same cycle uses old");
      chk(!cfg_err, "R9 same cycle no err", int'(cfg_err), 0);
      acc(32'h6000_0004);
      expect_hit("R9 new settings", 24'h00_5004, 1, 3);
      acc(32'h40AB_CDEF);
      expect_miss("R9 old region gone");
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      t_reset();
      t_basic();
      t_attr_bound();
      t_prio();
      t_disable();
      t_rejects();
      t_full_size();
      t_same_cycle();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (5000) @(posedge clk);
            checks++; errors++;
            $display("FAIL watchdog expired actual=0 expected=1");
         end
      join_any
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule